// File: doc/BRIEF.md
# Lane-Split Vector Integer Reducer

This block reduces a vector of packed integer elements to a single scalar. The vector is spread over a parameterised number of lanes. Each lane supplies 64-bit words, and each word packs 64/EEW elements of EEW bits. The operations are sum, signed and unsigned minimum and maximum, and bitwise and, or and xor.

A request carries the operation, the element width, a scalar seed and the number of words each lane holds. The reduction then runs in three phases:
- **Accumulate.** Each lane folds its own words into a private 64-bit partial, element by element.
- **Cross-lane tree.** The lane partials are combined pairwise in a tree. One further step merges the seed into lane 0. Every step of this phase waits a configurable transfer delay before it combines.
- **Fold.** The surviving 64-bit word is folded in halves until one element remains. That element is returned, sign- or zero-extended, on a result stream.

Requests, lane words and results each move over valid/ready handshakes:
- **Requests.** A request is taken only while the block is idle.
- **Lane words.** Lane words are taken only during the accumulate phase. A low `lane_valid` simply stalls that phase.
- **Results.** A result whose `res_ready` is low is held, unchanged, until it is taken. No new request is accepted in the meantime.

Top module: `xlane_reduce`

## Requirements
- R1: After reset, `req_ready` is 1, `lane_ready` is 0 and `res_valid` is 0.
- R2: `req_op` encodes 0 sum, 1 and, 2 or, 3 xor, 4 signed min, 5 signed max, 6 unsigned min, 7 unsigned max. `req_ew` encodes 0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 = 64-bit elements. Element i of a word occupies bits [i*EEW +: EEW].
- R3: The accumulate phase consumes exactly `req_words` beats, one per `lane_valid && lane_ready` cycle. Lane l's word is bits [l*64 +: 64] of `lane_data`. Words offered outside that phase, or beyond the count, have no effect on the result.
- R4: Every lane partial starts at the identity of the operation: 0 for sum, or, xor and unsigned max; all ones for and and unsigned min; the most positive value for signed min; the most negative value for signed max. With `req_words` = 0, the result is therefore the seed's low EEW bits, extended per R7.
- R5: The cross-lane phase takes log2(LANES)+1 steps. The last of these steps merges the seed's low EEW bits. Each step takes XFER_LAT+1 cycles, and the lane partials do not change during the waiting cycles of a step.
- R6: The fold phase takes log2(64/EEW) single-cycle steps. Each step combines the upper half of the active width with the lower half. Signed min/max compare the elements as two's-complement values.
- R7: `res_data` is the final EEW-bit element. It is sign-extended for sum, signed min and signed max, and zero-extended for the other operations.
- R8: When lane words arrive without gaps, `res_valid` rises exactly `req_words` + (log2(LANES)+1)*(XFER_LAT+1) + log2(64/EEW) cycles after the clock edge that accepted the request.
- R9: While `res_valid` is high and `res_ready` is low, `res_valid` stays high and `res_data` stays stable. The stored configuration does not change while `req_ready` is low.
- R10: For random data, `res_data` equals a sequential element-by-element reduction of the seed and all lane elements. This holds for every operation, every element width, and LANES of 1, 2, 4 and 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_op | input | 3 | Reduction operation (R2) |
| req_ew | input | 2 | Element width code (R2) |
| req_seed | input | 64 | Scalar seed, low EEW bits used |
| req_words | input | $clog2(MAX_WORDS+1) | Words per lane |
| lane_valid | input | 1 | Lane words on `lane_data` are valid |
| lane_ready | output | 1 | Accumulate phase is taking words |
| lane_data | input | LANES*64 | One 64-bit word per lane |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Consumer takes the result |
| res_data | output | 64 | Extended scalar result |

## Verification
The first result of a request is due exactly `req_words` + (log2(LANES)+1)*(XFER_LAT+1) + log2(64/EEW) cycles after the accepting edge, and only when lane words arrive without gaps. The bench counts clock edges from the negative edge after that acceptance to the first negative edge at which `res_valid` is seen, and compares the count against this formula. Transactions driven with deliberate `lane_valid` gaps skip that timing check and compare only the value. Results are compared at the negative edge before the handshaking clock edge, and a randomly toggled `res_ready` exercises the hold rule of R9 on the following negative edges.

// File: rtl/xlr_pkg.sv
package xlr_pkg;

  typedef enum logic [2:0] {
    RED_SUM  = 3'd0,
    RED_AND  = 3'd1,
    RED_OR   = 3'd2,
    RED_XOR  = 3'd3,
    RED_MIN  = 3'd4,
    RED_MAX  = 3'd5,
    RED_MINU = 3'd6,
    RED_MAXU = 3'd7
  } red_op_e;

  typedef enum logic [1:0] {
    EW8  = 2'd0,
    EW16 = 2'd1,
    EW32 = 2'd2,
    EW64 = 2'd3
  } ew_e;

  localparam int WORD_W = 64;

  function automatic logic [6:0] ew_bits(ew_e e);
    return 7'(8 << int'(e));
  endfunction

  function automatic logic [WORD_W-1:0] ew_mask(ew_e e);
    case (e)
      EW8:     return 64'h0000_0000_0000_00FF;
      EW16:    return 64'h0000_0000_0000_FFFF;
      EW32:    return 64'h0000_0000_FFFF_FFFF;
      default: return '1;
    endcase
  endfunction

  // One set bit at the top of every element for the given width.
  function automatic logic [WORD_W-1:0] ew_tops(ew_e e);
    case (e)
      EW8:     return 64'h8080_8080_8080_8080;
      EW16:    return 64'h8000_8000_8000_8000;
      EW32:    return 64'h8000_0000_8000_0000;
      default: return 64'h8000_0000_0000_0000;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] ident_word(red_op_e op, ew_e e);
    case (op)
      RED_AND, RED_MINU: return '1;
      RED_MIN:           return ~ew_tops(e);
      RED_MAX:           return ew_tops(e);
      default:           return '0;
    endcase
  endfunction

  function automatic logic op_signed(red_op_e op);
    return (op == RED_SUM) || (op == RED_MIN) || (op == RED_MAX);
  endfunction

endpackage

// File: rtl/xlr_elem.sv
module xlr_elem
  import xlr_pkg::*;
#(
  parameter int W = 8
) (
  input  red_op_e        op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [W-1:0]   y
);
  always_comb begin
    unique case (op)
      RED_SUM:  y = a + b;
      RED_AND:  y = a & b;
      RED_OR:   y = a | b;
      RED_XOR:  y = a ^ b;
      RED_MIN:  y = ($signed(a) < $signed(b)) ? a : b;
      RED_MAX:  y = ($signed(a) > $signed(b)) ? a : b;
      RED_MINU: y = (a < b) ? a : b;
      default:  y = (a > b) ? a : b;
    endcase
  end
endmodule

// File: rtl/xlr_simd_alu.sv
module xlr_simd_alu
  import xlr_pkg::*;
(
  input  red_op_e            op,
  input  ew_e                ew,
  input  logic [WORD_W-1:0]  a,
  input  logic [WORD_W-1:0]  b,
  output logic [WORD_W-1:0]  y
);
  localparam int N_EW = 4;

  logic [N_EW-1:0][WORD_W-1:0] y_w;

  // One element-wise slice per supported width; the width code selects one.
  for (genvar g = 0; g < N_EW; g++) begin : g_width
    localparam int W = 8 << g;
    localparam int N = WORD_W / W;
    for (genvar e = 0; e < N; e++) begin : g_elem
      xlr_elem #(.W(W)) u_elem (
        .op (op),
        .a  (a[e*W +: W]),
        .b  (b[e*W +: W]),
        .y  (y_w[g][e*W +: W])
      );
    end
  end

  assign y = y_w[ew];
endmodule

// File: rtl/xlane_reduce.sv
module xlane_reduce
  import xlr_pkg::*;
#(
  parameter int LANES     = 4,
  parameter int MAX_WORDS = 16,
  parameter int XFER_LAT  = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic [2:0]                    req_op,
  input  logic [1:0]                    req_ew,
  input  logic [63:0]                   req_seed,
  input  logic [$clog2(MAX_WORDS+1)-1:0] req_words,
  input  logic                          lane_valid,
  output logic                          lane_ready,
  input  logic [LANES*64-1:0]           lane_data,
  output logic                          res_valid,
  input  logic                          res_ready,
  output logic [63:0]                   res_data
);
  localparam int LG     = $clog2(LANES);
  localparam int CNT_W  = $clog2(MAX_WORDS + 1);
  localparam int STEP_W = $clog2(LG + 2);
  localparam int WAIT_W = (XFER_LAT > 0) ? $clog2(XFER_LAT + 1) : 1;

  typedef enum logic [2:0] {ST_IDLE, ST_ACC, ST_XLANE, ST_FOLD, ST_DONE} st_e;

  st_e                 st;
  red_op_e             op_q;
  ew_e                 ew_q;
  logic [63:0]         seed_q;
  logic [CNT_W-1:0]    words_q;
  logic [CNT_W-1:0]    beat_q;
  logic [STEP_W-1:0]   step_q;
  logic [WAIT_W-1:0]   wait_q;
  logic [6:0]          half_q;
  logic [63:0]         acc    [LANES];
  logic [63:0]         b_opnd [LANES];
  logic [63:0]         alu_y  [LANES];

  logic [63:0] ident_w, seed_w;
  logic        seed_step, wait_done, apply;

  assign ident_w   = ident_word(op_q, ew_q);
  assign seed_w    = (ident_w & ~ew_mask(ew_q)) | (seed_q & ew_mask(ew_q));
  assign seed_step = (step_q == STEP_W'(LG));
  assign wait_done = (wait_q == WAIT_W'(XFER_LAT));
  assign apply     = (st == ST_ACC && lane_valid) ||
                     (st == ST_XLANE && wait_done) ||
                     (st == ST_FOLD);

  // Second operand of every lane ALU, picked by phase.
  always_comb begin
    int stride;
    stride = LANES >> (int'(step_q) + 1);
    for (int l = 0; l < LANES; l++) begin
      b_opnd[l] = ident_w;
      unique case (st)
        ST_ACC:   b_opnd[l] = lane_data[l*64 +: 64];
        ST_XLANE: begin
          if (seed_step) begin
            if (l == 0) b_opnd[l] = seed_w;
          end else begin
            for (int j = 0; j < LANES; j++)
              if (l < stride && j == l + stride) b_opnd[l] = acc[j];
          end
        end
        ST_FOLD:  if (l == 0) b_opnd[l] = acc[0] >> half_q;
        default:  ;
      endcase
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    xlr_simd_alu u_alu (
      .op (op_q),
      .ew (ew_q),
      .a  (acc[l]),
      .b  (b_opnd[l]),
      .y  (alu_y[l])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      op_q    <= RED_SUM;
      ew_q    <= EW8;
      seed_q  <= '0;
      words_q <= '0;
      beat_q  <= '0;
      step_q  <= '0;
      wait_q  <= '0;
      half_q  <= 7'd32;
      for (int l = 0; l < LANES; l++) acc[l] <= '0;
    end else begin
      if (apply)
        for (int l = 0; l < LANES; l++) acc[l] <= alu_y[l];
      unique case (st)
        ST_IDLE: if (req_valid) begin
          op_q    <= red_op_e'(req_op);
          ew_q    <= ew_e'(req_ew);
          seed_q  <= req_seed;
          words_q <= req_words;
          beat_q  <= '0;
          step_q  <= '0;
          wait_q  <= '0;
          half_q  <= 7'd32;
          for (int l = 0; l < LANES; l++)
            acc[l] <= ident_word(red_op_e'(req_op), ew_e'(req_ew));
          st <= (req_words == '0) ? ST_XLANE : ST_ACC;
        end
        ST_ACC: if (lane_valid) begin
          beat_q <= beat_q + 1'b1;
          if (beat_q == words_q - 1'b1) st <= ST_XLANE;
        end
        ST_XLANE: begin
          if (wait_done) begin
            wait_q <= '0;
            step_q <= step_q + 1'b1;
            if (seed_step) st <= (ew_q == EW64) ? ST_DONE : ST_FOLD;
          end else begin
            wait_q <= wait_q + 1'b1;
          end
        end
        ST_FOLD: begin
          if (half_q == ew_bits(ew_q)) st <= ST_DONE;
          else half_q <= half_q >> 1;
        end
        default: if (res_ready) st <= ST_IDLE;
      endcase
    end
  end

  assign req_ready  = (st == ST_IDLE);
  assign lane_ready = (st == ST_ACC);
  assign res_valid  = (st == ST_DONE);

  always_comb begin
    logic [63:0] r;
    r = acc[0];
    if (op_signed(op_q)) begin
      unique case (ew_q)
        EW8:     res_data = {{56{r[7]}},  r[7:0]};
        EW16:    res_data = {{48{r[15]}}, r[15:0]};
        EW32:    res_data = {{32{r[31]}}, r[31:0]};
        default: res_data = r;
      endcase
    end else begin
      res_data = r & ew_mask(ew_q);
    end
  end

  // R9: a stalled result neither drops nor changes.
  a_r9_res_hold: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_data));

  // R9: stored configuration only changes at an accepting edge.
  a_r9_cfg_held: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |=> $stable(seed_q) && $stable(op_q) && $stable(ew_q));

  // R3: never asks for more words than requested.
  a_r3_beat_bound: assert property (@(posedge clk) disable iff (!rst_n)
    lane_ready |-> beat_q < words_q);

  // R5: partials hold during the transfer wait of a cross-lane step.
  a_r5_wait_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_XLANE) && !wait_done |=> $stable(acc[0]));

  // R6: the fold never narrows below one element.
  a_r6_fold_width: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_FOLD) |-> half_q >= ew_bits(ew_q));

endmodule

// File: tb/test_xlane_reduce.sv
module xlr_lane_bench
  import xlr_pkg::*;
#(
  parameter int L    = 4,
  parameter int MAXW = 16,
  parameter int XL   = 2
) (
  input  logic clk,
  input  logic rst_n,
  output int   n_chk,
  output int   n_bad,
  output bit   fin
);
  localparam int LG    = $clog2(L);
  localparam int CNT_W = $clog2(MAXW + 1);

  logic                 req_valid, req_ready, lane_valid, lane_ready, res_valid, res_ready;
  logic [2:0]           req_op;
  logic [1:0]           req_ew;
  logic [63:0]          req_seed, res_data;
  logic [CNT_W-1:0]     req_words;
  logic [L*64-1:0]      lane_data;

  xlane_reduce #(.LANES(L), .MAX_WORDS(MAXW), .XFER_LAT(XL)) i_xlane_reduce (
    .clk, .rst_n, .req_valid, .req_ready, .req_op, .req_ew, .req_seed, .req_words,
    .lane_valid, .lane_ready, .lane_data, .res_valid, .res_ready, .res_data
  );

  int cyc = 0;
  always @(posedge clk) cyc++;

  logic [63:0] dat [L][MAXW];
  logic [63:0] q_exp [$];
  string       q_tag [$];
  int          q_lat [$];
  int          q_t0  [$];
  bit          q_on  [$];
  int          pend = 0;

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s L=%0d %s actual=%h expected=%h", req, L, what, act, exp);
    end
  endtask

  function automatic logic [63:0] msk(int w);
    return (w == 64) ? '1 : ((64'd1 << w) - 1);
  endfunction

  function automatic logic [63:0] ref_elem(int op, int w, logic [63:0] a, logic [63:0] b);
    logic [63:0] m;
    logic signed [63:0] sa, sb;
    m = msk(w); a &= m; b &= m;
    sa = $signed(a << (64 - w)) >>> (64 - w);
    sb = $signed(b << (64 - w)) >>> (64 - w);
    case (op)
      0: return (a + b) & m;
      1: return a & b;
      2: return a | b;
      3: return a ^ b;
      4: return (sa < sb) ? a : b;
      5: return (sa > sb) ? a : b;
      6: return (a < b) ? a : b;
      default: return (a > b) ? a : b;
    endcase
  endfunction

  function automatic logic [63:0] ref_ext(int op, int w, logic [63:0] v);
    if (op == 0 || op == 4 || op == 5) return $signed(v << (64 - w)) >>> (64 - w);
    return v & msk(w);
  endfunction

  task automatic fill_rand();
    for (int l = 0; l < L; l++)
      for (int k = 0; k < MAXW; k++) dat[l][k] = {$urandom, $urandom};
  endtask

  // Drives one request and its lane words; pushes the expected result.
  task automatic run(int op, int ew, logic [63:0] seed, int words, bit gaps, string tag);
    int w, lat;
    logic [63:0] acc;
    w   = 8 << ew;
    acc = seed & msk(w);
    for (int l = 0; l < L; l++)
      for (int k = 0; k < words; k++)
        for (int e = 0; e < 64 / w; e++)
          acc = ref_elem(op, w, acc, dat[l][k] >> (e * w));
    lat = words + (LG + 1) * (XL + 1) + (3 - ew);
    @(negedge clk);
    lane_valid = 0;
    req_valid  = 1;
    req_op     = 3'(op);
    req_ew     = 2'(ew);
    req_seed   = seed;
    req_words  = CNT_W'(words);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    req_seed  = {$urandom, $urandom};
    q_exp.push_back(ref_ext(op, w, acc));
    q_tag.push_back(tag);
    q_lat.push_back(lat);
    q_t0.push_back(cyc);
    q_on.push_back(!gaps);
    pend++;
    for (int k = 0; k < words; k++) begin
      if (gaps && ($urandom % 2 == 1)) begin
        lane_valid = 0;
        lane_data  = {L{64'hDEAD_BEEF_0BAD_F00D}};
        @(negedge clk);
      end
      lane_valid = 1;
      for (int l = 0; l < L; l++) lane_data[l*64 +: 64] = dat[l][k];
      while (!lane_ready) @(negedge clk);
      @(negedge clk);
    end
    // R3: junk words kept valid after the count must be ignored.
    lane_valid = 1;
    for (int l = 0; l < L; l++) lane_data[l*64 +: 64] = {$urandom, $urandom};
    while (pend != 0) @(negedge clk);
  endtask

  // Monitor: timing, hold rule and value comparison.
  initial begin
    bit          seen = 0, held = 0;
    logic [63:0] held_d = '0;
    res_ready = 0;
    forever begin
      @(negedge clk);
      if (held)
        chk(res_valid && res_data == held_d, "R9", "stalled result held", res_data, held_d);
      if (res_valid && !seen && q_exp.size() != 0) begin
        seen = 1;
        if (q_on[0])
          chk(cyc - q_t0[0] == q_lat[0], "R8", "result latency",
              64'(cyc - q_t0[0]), 64'(q_lat[0]));
      end
      res_ready = ($urandom % 3 != 0);
      held = 0;
      if (res_valid && !res_ready) begin held = 1; held_d = res_data; end
      if (res_valid && res_ready && q_exp.size() != 0) begin
        chk(res_data == q_exp[0], q_tag[0], "result value", res_data, q_exp[0]);
        void'(q_exp.pop_front()); void'(q_tag.pop_front()); void'(q_lat.pop_front());
        void'(q_t0.pop_front());  void'(q_on.pop_front());
        pend--;
        seen = 0;
      end
    end
  end

  initial begin
    n_chk = 0; n_bad = 0; fin = 0;
    req_valid = 0; req_op = '0; req_ew = '0; req_seed = '0; req_words = '0;
    lane_valid = 0; lane_data = '0;
    @(posedge rst_n);
    @(negedge clk);
    chk(req_ready && !lane_ready && !res_valid, "R1", "idle after reset",
        {61'd0, req_ready, lane_ready, res_valid}, 64'd4);
    // R2 R6 R7 R10: every operation at every width.
    for (int op = 0; op < 8; op++)
      for (int ew = 0; ew < 4; ew++) begin
        fill_rand();
        run(op, ew, {$urandom, $urandom}, 3, 0, "R10");
      end
    // R4: empty lanes leave only the seed.
    for (int op = 0; op < 8; op++) begin
      fill_rand();
      run(op, 1, {$urandom, $urandom}, 0, 0, "R4");
    end
    // R6 R7: every element the most negative byte, signed max keeps it, sign-extended.
    for (int l = 0; l < L; l++)
      for (int k = 0; k < MAXW; k++) dat[l][k] = 64'h8080_8080_8080_8080;
    run(5, 0, 64'h80, MAXW, 0, "R6");
    // R6: unsigned min of the same data, zero-extended.
    run(6, 0, 64'hFF, MAXW, 0, "R7");
    // R5: seed dominates a signed min over positive data.
    fill_rand();
    for (int l = 0; l < L; l++)
      for (int k = 0; k < MAXW; k++) dat[l][k] &= 64'h7FFF_7FFF_7FFF_7FFF;
    run(4, 1, 64'h8000, 5, 0, "R5");
    // R3 R10: random traffic with lane stalls.
    for (int t = 0; t < 20; t++) begin
      fill_rand();
      run($urandom % 8, $urandom % 4, {$urandom, $urandom}, $urandom % (MAXW + 1), 1, "R3");
    end
    fin = 1;
  end
endmodule

module test_xlane_reduce;
  logic clk = 0;
  logic rst_n = 0;
  always #2.5 clk = ~clk;

  int n_chk [4];
  int n_bad [4];
  bit fin   [4];

  for (genvar gi = 0; gi < 4; gi++) begin : g_l
    xlr_lane_bench #(.L(1 << gi), .MAXW(16), .XL(2)) u_bench (
      .clk   (clk),
      .rst_n (rst_n),
      .n_chk (n_chk[gi]),
      .n_bad (n_bad[gi]),
      .fin   (fin[gi])
    );
  end

  initial begin
    int cycles = 0, tot = 0, bad = 0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    while (!(fin[0] && fin[1] && fin[2] && fin[3]) && cycles < 150000) begin
      @(negedge clk);
      cycles++;
    end
    for (int i = 0; i < 4; i++) begin tot += n_chk[i]; bad += n_bad[i]; end
    if (cycles >= 150000) begin
      tot++; bad++;
      $display("FAIL watchdog: run did not complete, actual=%0d expected<150000 cycles", cycles);
    end
    $display("  %0d/%0d checks passed", tot - bad, tot);
    $finish;
  end
endmodule